// File: doc/BRIEF.md
# Selectable-Length SAR Conversion Sequencer

This block is the digital heart of a 12-bit successive-approximation converter. A falling edge on the read/convert control input, qualified by an active chip enable and an active-low chip select, launches a conversion. From then on the sequencer resolves one bit per clock, from the most significant bit downward. In each cycle it presents a trial word to the external DAC and keeps or clears the trial bit according to the comparator decision it samples. A busy flag stays high while bits are being resolved.

At the launching edge the sequencer captures a length-select input. When the captured value is high the sequence stops after eight bits. The word then holds the eight resolved upper bits, followed by the next trial bit still set and zeros below it. When the captured value is low, all twelve bits are resolved. No other control input is held. Start requests that arrive while a conversion is running are dropped. The word stays frozen between conversions, so a separate read interface can take it as soon as busy falls.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted, and right after it, `busy_o` is low and `code_o` is all zeros.
- R2: A conversion is accepted only on a clock edge where `rc_i` was high at the previous edge and is low now, with `ce_i` high, `cs_ni` low and no conversion running. A rising edge of `rc_i`, or a falling edge with `ce_i` low or `cs_ni` high, starts nothing. In the cycle after acceptance `code_o` holds only bit 11 set.
- R3: After acceptance `busy_o` stays high for exactly 12 clock cycles when the captured length select was low, and exactly 8 when it was high.
- R4: Each busy cycle resolves the current trial bit, starting at bit 11 and moving down. A comparator input of 1 keeps the bit and 0 clears it, and the next lower bit becomes the new trial bit (set to 1) in `code_o`. With a comparator that returns 1 when the analog value is at least the trial word, a full conversion yields the input code exactly.
- R5: After an 8-bit conversion, bits 11..4 of `code_o` are the resolved bits, bit 3 is 1 and bits 2..0 are 0.
- R6: `len_sel_i` is sampled only at acceptance. Changing it during a conversion alters neither the length nor the result.
- R7: A valid start edge that arrives while `busy_o` is high, including during the final resolving cycle, is ignored. The running conversion finishes unchanged and no new one begins.
- R8: While no conversion is running and none is accepted, `code_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_i | input | 1 | Read/convert control; a falling edge requests a conversion |
| ce_i | input | 1 | Chip enable, active high, used at its live level |
| cs_ni | input | 1 | Chip select, active low, used at its live level |
| len_sel_i | input | 1 | Length select: 1 = 8 bits, 0 = 12 bits; captured at acceptance |
| cmp_i | input | 1 | Comparator decision for the current trial word |
| busy_o | output | 1 | High while a conversion is in progress |
| code_o | output | 12 | Trial word during conversion, result when idle |

## Verification
Two things can land on the same edge: the last bit is resolved and busy falls, while a fresh falling edge on read/convert asks for a new conversion. The bench provokes this by timing a read/convert pulse so that its falling edge coincides with the final resolving edge, across many codes in both lengths. It then checks that busy stays low afterwards and that the completed word matches the code computed in the bench. The same sweeps also flip the length select partway through some conversions, so that the point where the captured length ends the sequence is judged against a select value that has since changed.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } len_e;

endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rc_i,
    input  logic ce_i,
    input  logic cs_ni,
    output logic fall_o
);

    typedef struct packed {
        logic rc;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d    = det_q;
        det_d.rc = rc_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // high-to-low transition of read/convert, qualified by live enables
    assign fall_o = det_q.rc & ~rc_i & ce_i & ~cs_ni;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int SHORT_LEN = 8,
    localparam int IW       = $clog2(WIDTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          len_i,
    output logic          accept_o,
    output logic          busy_o,
    output logic          short_o,
    output logic          last_o,
    output logic [IW-1:0] idx_o
);

    localparam logic [IW-1:0] MSB_IDX    = IW'(WIDTH - 1);
    localparam logic [IW-1:0] STOP_SHORT = IW'(WIDTH - SHORT_LEN);

    typedef struct packed {
        logic          busy;
        len_e          mode;
        logic [IW-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [IW-1:0] stop_idx;
    logic          last;
    logic          accept;

    always_comb begin
        stop_idx = (ctl_q.mode == LEN_SHORT) ? STOP_SHORT : '0;
        last     = ctl_q.busy && (ctl_q.idx == stop_idx);
        accept   = start_i && !ctl_q.busy;
        ctl_d    = ctl_q;
        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.mode = len_i ? LEN_SHORT : LEN_FULL;
            ctl_d.idx  = MSB_IDX;
        end else if (ctl_q.busy) begin
            if (last) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.idx = ctl_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{busy: 1'b0, mode: LEN_FULL, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign accept_o = accept;
    assign busy_o   = ctl_q.busy;
    assign short_o  = (ctl_q.mode == LEN_SHORT);
    assign last_o   = last;
    assign idx_o    = ctl_q.idx;

    // R6: captured length cannot move while a conversion runs
    p_len_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.busy |=> $stable(ctl_q.mode));

    // R7: a start request during busy never restarts the bit walk
    p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.busy && !last) |=> (ctl_q.busy && (ctl_q.idx == $past(ctl_q.idx) - 1'b1)));

    // R7: the final resolving cycle is always followed by idle
    p_end_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last |=> !ctl_q.busy);

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int WIDTH = 12,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [IW-1:0]    idx_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] code_o
);

    typedef struct packed {
        logic [WIDTH-1:0] code;
    } res_t;

    res_t res_d, res_q;
    logic [WIDTH-1:0] bit_nx;
    logic [IW:0]      idx_w;

    assign idx_w = {1'b0, idx_i};

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic hit;
        logic below;
        assign hit   = (idx_w == (IW+1)'(b));
        assign below = (idx_w == (IW+1)'(b + 1));
        assign bit_nx[b] = load_i          ? (b == WIDTH - 1)
                         : (step_i & hit)   ? cmp_i
                         : (step_i & below) ? 1'b1
                         : res_q.code[b];
    end

    always_comb begin
        res_d      = res_q;
        res_d.code = bit_nx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign code_o = res_q.code;

    // R8: idle word is frozen
    p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(code_o));

    // R2: an accepted start leaves only the top trial bit set
    p_first_trial_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (code_o == {1'b1, {(WIDTH-1){1'b0}}}));

    // R4: the resolved bit follows the sampled comparator decision
    p_decide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (code_o[$past(idx_i)] == $past(cmp_i)));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int SHORT_LEN = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rc_i,
    input  logic             ce_i,
    input  logic             cs_ni,
    input  logic             len_sel_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] code_o
);

    localparam int IW   = $clog2(WIDTH);
    localparam int CW   = $clog2(WIDTH + 1);
    localparam int STOP = WIDTH - SHORT_LEN;
    localparam logic [WIDTH-1:0] TAIL_PAT  = WIDTH'(1) << (STOP - 1);
    localparam logic [WIDTH-1:0] TAIL_MASK = (WIDTH'(1) << STOP) - 1'b1;

    logic          fall;
    logic          accept;
    logic          busy;
    logic          short_len;
    logic          last;
    logic [IW-1:0] idx;

    sar_start_det u_det (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rc_i   (rc_i),
        .ce_i   (ce_i),
        .cs_ni  (cs_ni),
        .fall_o (fall)
    );

    sar_ctrl #(
        .WIDTH     (WIDTH),
        .SHORT_LEN (SHORT_LEN)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (fall),
        .len_i    (len_sel_i),
        .accept_o (accept),
        .busy_o   (busy),
        .short_o  (short_len),
        .last_o   (last),
        .idx_o    (idx)
    );

    sar_result_reg #(
        .WIDTH (WIDTH)
    ) u_res (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept),
        .step_i (busy),
        .idx_i  (idx),
        .cmp_i  (cmp_i),
        .code_o (code_o)
    );

    assign busy_o = busy;

    // busy-cycle counter for the length check
    logic [CW-1:0] span_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            span_q <= '0;
        end else if (accept) begin
            span_q <= '0;
        end else if (busy) begin
            span_q <= span_q + 1'b1;
        end
    end

    // R1: reset clears status and word
    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!busy_o && (code_o == '0)));

    // R3: busy lasts exactly the captured length
    p_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (span_q == (short_len ? CW'(SHORT_LEN) : CW'(WIDTH))));

    // R5: short conversion leaves trial one then zeros below
    p_short_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy_o) && short_len) |-> ((code_o & TAIL_MASK) == TAIL_PAT));

    // R2: an accepted edge always raises busy
    p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> busy_o);

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb_top;

    localparam int W = 12;
    localparam int S = 8;
    localparam int LIMIT = 190000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rc = 1'b0;
    logic         ce = 1'b1;
    logic         cs_n = 1'b0;
    logic         len_sel = 1'b0;
    logic         cmp;
    logic         busy;
    logic [W-1:0] code;
    logic [W-1:0] vin = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    // ideal comparator: keep trial bit when input is at least the trial word
    assign cmp = (vin >= code);

    sar_seq #(.WIDTH(W), .SHORT_LEN(S)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .rc_i      (rc),
        .ce_i      (ce),
        .cs_ni     (cs_n),
        .len_sel_i (len_sel),
        .cmp_i     (cmp),
        .busy_o    (busy),
        .code_o    (code)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // one conversion; flip toggles len_sel mid-way, poke fires a start while busy
    task automatic convert(input int v, input bit short_m, input bit flip, input int poke);
        int n;
        int exp_code;
        int exp_len;
        logic [W-1:0] held;
        exp_len  = short_m ? S : W;
        exp_code = short_m ? ((v & ((1 << W) - (1 << (W - S)))) | (1 << (W - S - 1))) : v;
        @(negedge clk);
        vin = W'(v);
        len_sel = short_m;
        rc = 1'b1;
        @(negedge clk);
        rc = 1'b0;
        @(negedge clk);
        chk("R2 first trial", int'(code), 1 << (W - 1));
        n = 0;
        while (busy && n < 40) begin
            n++;
            if (flip && n == 3) len_sel = ~len_sel;
            if (n == poke) rc = 1'b1;
            if (n == poke + 1) rc = 1'b0;
            @(negedge clk);
        end
        chk(short_m ? "R3 short length" : "R3 full length", n, exp_len);
        chk(short_m ? "R5 short word" : "R4 full word", int'(code), exp_code);
        if (flip) chk("R6 length held", n, exp_len);
        held = code;
        @(negedge clk);
        @(negedge clk);
        if (poke >= 0) chk("R7 start during busy ignored", int'(busy), 0);
        chk("R8 idle hold", int'(code), int'(held));
    endtask

    initial begin
        rst_n = 1'b0;
        #1;
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 code in reset", int'(code), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 code after reset", int'(code), 0);

        // R2: rising edge alone starts nothing
        rc = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 rising edge no start", int'(busy), 0);
        // R2: falling edge with chip enable low
        ce = 1'b0;
        rc = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 ce low no start", int'(busy), 0);
        chk("R8 code after gated edge", int'(code), 0);
        // R2: falling edge with chip select high
        ce = 1'b1;
        cs_n = 1'b1;
        rc = 1'b1;
        @(negedge clk);
        rc = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 cs high no start", int'(busy), 0);
        cs_n = 1'b0;

        // full-length sweep over every code
        for (int v = 0; v < (1 << W); v++) begin
            convert(v, 1'b0, (v % 5) == 1, ((v % 7) == 0) ? W - 1 : (((v % 11) == 0) ? 4 : -1));
        end
        // short-length sweep over every code
        for (int v = 0; v < (1 << W); v++) begin
            convert(v, 1'b1, (v % 5) == 2, ((v % 7) == 3) ? S - 1 : -1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=%0d", LIMIT, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule